// File: doc/BRIEF.md
# Decimating Sample Capture Buffer

This block sits between a high-rate ADC sample stream and a byte-wide serial readout path. Samples arrive with a valid strobe at up to one per clock. A small rate code picks a decimation ratio of 1 + code, so code 0 keeps every sample, code 1 every second sample, code 2 every third sample and code 3 every fourth sample. Only samples that arrive while the sequencer holds the acquisition window open are stored. They go into an on-chip memory in arrival order.

After capture, the serial slave pulls the stored samples out one byte per request. Each sample is zero-extended to 16 bits and sent as its high byte and then its low byte. When the stored data has been drained, a further request returns 0x00. A host that reads twice the sample count plus one byte therefore finishes on a zero. A pointer-clear command empties the buffer before a new acquisition. It resets the write count, the read pointer and the decimation phase.

Top module: `cap_buffer`

## Requirements
- R1: After reset, `wr_count` is 0, `buf_full` is 0 and `rd_vld` is 0.
- R2: With `rate_code` 0, every sample with `smp_vld` high inside the window is stored.
- R3: With `rate_code` k, the valid samples in the window are taken in groups of k+1, and only the first sample of each group is stored. Cycles with `smp_vld` low do not count toward a group.
- R4: No sample is stored while `acq_win` is low, whatever `smp_vld` does.
- R5: The decimation phase restarts whenever `acq_win` is low, so the first valid sample of every window is stored.
- R6: Every `rd_req` pulse produces `rd_vld` high in the following cycle, with one byte on `rd_data`. For each stored sample in write order, the first byte is bits 15..8 and the second byte is bits 7..0 of the sample zero-extended to 16 bits.
- R7: A request made when every stored sample has been read returns 0x00 and does not move the read pointer.
- R8: Storage stops after DEPTH samples. At that point `buf_full` goes high and `wr_count` holds at DEPTH.
- R9: `ptr_clr` sets `wr_count` to 0, returns the read pointer to the first sample and the byte order to high byte first, and restarts the decimation phase. It takes priority over a write or a read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | A sample is present on `smp_data` |
| smp_data | input | SAMPLE_W | ADC sample |
| rate_code | input | RATE_W | Decimation code, ratio 1 + code |
| acq_win | input | 1 | Acquisition window from the sequencer |
| ptr_clr | input | 1 | Clear write count, read pointer and phase |
| rd_req | input | 1 | Request one readout byte |
| rd_data | output | 8 | Readout byte |
| rd_vld | output | 1 | `rd_data` answers the request of the previous cycle |
| buf_full | output | 1 | DEPTH samples stored |
| wr_count | output | clog2(DEPTH)+1 | Number of stored samples |

## Verification
The bench uses a decimation code of 2 to catch a divider that counts one too few or one too many. It gaps the valid strobe so that a design counting clock cycles instead of samples keeps the wrong samples. A window that closes in the middle of a group checks that the phase restarts; a design that keeps the phase would skip the first sample of the next window. It overfills the buffer to catch a write pointer that wraps and overwrites early data. It reads past the end to catch a design that returns stale bytes or runs the read pointer past the write count. A clear issued between the high and low byte of a sample must bring back high-byte-first order.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  typedef enum logic {
    PH_HI = 1'b0,
    PH_LO = 1'b1
  } byte_phase_e;
endpackage

// File: rtl/cap_decim.sv
module cap_decim #(
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              win,
  input  logic              vld,
  input  logic [RATE_W-1:0] code,
  output logic              keep
);
  logic [RATE_W-1:0] phase_q, phase_d;

  always_comb begin
    keep    = win && vld && (phase_q == '0);
    phase_d = phase_q;
    if (clr || !win)
      phase_d = '0;
    else if (vld)
      phase_d = (phase_q >= code) ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  // R5: a closed window leaves the next in-window sample kept
  a_r5_window_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !win |=> (!(win && vld) || keep));
endmodule

// File: rtl/cap_mem.sv
module cap_mem #(
  parameter int SAMPLE_W = 10,
  parameter int DEPTH    = 16,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                we,
  input  logic [ADDR_W-1:0]   waddr,
  input  logic [SAMPLE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]   raddr,
  output logic [SAMPLE_W-1:0] rdata
);
  logic [SAMPLE_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/cap_reader.sv
module cap_reader
  import cap_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int DEPTH    = 16,
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int CNT_W   = ADDR_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                rd_req,
  input  logic [CNT_W-1:0]    wr_cnt,
  input  logic [SAMPLE_W-1:0] word,
  output logic [ADDR_W-1:0]   rd_addr,
  output logic [BYTE_W-1:0]   rd_data,
  output logic                rd_vld
);
  logic [CNT_W-1:0]  ptr_q, ptr_d;
  byte_phase_e       ph_q, ph_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic              vld_q;
  logic [WORD_W-1:0] ext;
  logic              empty;

  assign ext     = WORD_W'(word);
  assign empty   = (ptr_q == wr_cnt);
  assign rd_addr = ptr_q[ADDR_W-1:0];

  always_comb begin
    ptr_d  = ptr_q;
    ph_d   = ph_q;
    data_d = data_q;
    if (clr) begin
      ptr_d  = '0;
      ph_d   = PH_HI;
      data_d = '0;
    end else if (rd_req) begin
      if (empty) begin
        data_d = '0;
      end else if (ph_q == PH_HI) begin
        data_d = ext[WORD_W-1:BYTE_W];
        ph_d   = PH_LO;
      end else begin
        data_d = ext[BYTE_W-1:0];
        ph_d   = PH_HI;
        ptr_d  = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      ph_q   <= PH_HI;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      ph_q   <= ph_d;
      data_q <= data_d;
      vld_q  <= rd_req;
    end
  end

  assign rd_data = data_q;
  assign rd_vld  = vld_q;

  // R6: each request answered exactly one cycle later
  a_r6_vld_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_vld);
  a_r6_no_spurious_vld: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_vld);
  // R7: drained buffer answers zero and keeps its pointer
  a_r7_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !clr && ptr_q == wr_cnt) |=> (rd_data == '0 && $stable(ptr_q)));
endmodule

// File: rtl/cap_buffer.sv
module cap_buffer
  import cap_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int DEPTH    = 16,
  parameter int RATE_W   = 2,
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int CNT_W   = ADDR_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_vld,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [RATE_W-1:0]   rate_code,
  input  logic                acq_win,
  input  logic                ptr_clr,
  input  logic                rd_req,
  output logic [BYTE_W-1:0]   rd_data,
  output logic                rd_vld,
  output logic                buf_full,
  output logic [CNT_W-1:0]    wr_count
);
  logic              keep;
  logic              wr_en;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] rd_addr;
  logic [SAMPLE_W-1:0] rd_word;

  cap_decim #(.RATE_W(RATE_W)) u_decim (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (ptr_clr),
    .win  (acq_win),
    .vld  (smp_vld),
    .code (rate_code),
    .keep (keep)
  );

  assign buf_full = (cnt_q == CNT_W'(DEPTH));
  assign wr_en    = keep && !buf_full && !ptr_clr;

  always_comb begin
    cnt_d = cnt_q;
    if (ptr_clr)    cnt_d = '0;
    else if (wr_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign wr_count = cnt_q;

  cap_mem #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) u_mem (
    .clk  (clk),
    .we   (wr_en),
    .waddr(cnt_q[ADDR_W-1:0]),
    .wdata(smp_data),
    .raddr(rd_addr),
    .rdata(rd_word)
  );

  cap_reader #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) u_reader (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (ptr_clr),
    .rd_req (rd_req),
    .wr_cnt (cnt_q),
    .word   (rd_word),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .rd_vld (rd_vld)
  );

  // R8: count never moves while full unless cleared
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && !ptr_clr) |=> $stable(wr_count));
  // R4: closed window stores nothing
  a_r4_closed_window: assert property (@(posedge clk) disable iff (!rst_n)
    (!acq_win && !ptr_clr) |=> $stable(wr_count));
  // R9: clear empties the buffer
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> (wr_count == '0 && !buf_full));
endmodule

// File: tb/sim_cap_buffer.sv
module sim_cap_buffer;
  localparam int SW = 10;
  localparam int DP = 16;
  localparam int CW = $clog2(DP) + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          smp_vld;
  logic [SW-1:0] smp_data;
  logic [1:0]    rate_code;
  logic          acq_win;
  logic          ptr_clr;
  logic          rd_req;
  logic [7:0]    rd_data;
  logic          rd_vld;
  logic          buf_full;
  logic [CW-1:0] wr_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cap_buffer #(.SAMPLE_W(SW), .DEPTH(DP), .RATE_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .rate_code(rate_code), .acq_win(acq_win), .ptr_clr(ptr_clr),
    .rd_req(rd_req), .rd_data(rd_data), .rd_vld(rd_vld),
    .buf_full(buf_full), .wr_count(wr_count)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_buf();
    @(negedge clk) ptr_clr = 1'b1;
    @(negedge clk) ptr_clr = 1'b0;
  endtask

  task automatic push(logic [SW-1:0] d, logic v, logic w);
    @(negedge clk);
    smp_vld = v; smp_data = d; acq_win = w;
  endtask

  task automatic idle();
    @(negedge clk);
    smp_vld = 1'b0; acq_win = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_byte(string req, int exp);
    @(negedge clk) rd_req = 1'b1;
    @(negedge clk) rd_req = 1'b0;
    check({req, " rd_vld"}, int'(rd_vld), 1);
    check(req, int'(rd_data), exp);
  endtask

  task automatic read_word(string req, int val);
    read_byte(req, (val >> 8) & 8'hFF);
    read_byte(req, val & 8'hFF);
  endtask

  task automatic t_reset();
    check("R1 count", int'(wr_count), 0);
    check("R1 full", int'(buf_full), 0);
    check("R1 rd_vld", int'(rd_vld), 0);
  endtask

  task automatic t_every_sample();
    clear_buf();
    rate_code = 2'd0;
    push(10'h3A5, 1, 1); push(10'h001, 1, 1);
    push(10'h200, 1, 1); push(10'h0FF, 1, 1);
    idle();
    check("R2 count", int'(wr_count), 4);
    read_word("R2/R6 s0", 16'h03A5);
    read_word("R2/R6 s1", 16'h0001);
    read_word("R2/R6 s2", 16'h0200);
    read_word("R2/R6 s3", 16'h00FF);
    read_byte("R7 trailing", 0);
    read_byte("R7 repeat", 0);
  endtask

  task automatic t_div3();
    clear_buf();
    rate_code = 2'd2;
    for (int i = 0; i < 7; i++) push(SW'(10 + i), 1, 1);
    idle();
    check("R3 div3 count", int'(wr_count), 3);
    read_word("R3 div3 k0", 10);
    read_word("R3 div3 k1", 13);
    read_word("R3 div3 k2", 16);
    read_byte("R7 div3 end", 0);
  endtask

  task automatic t_gapped();
    clear_buf();
    rate_code = 2'd1;
    for (int i = 0; i < 4; i++) begin
      push(SW'(20 + i), 1, 1);
      push(10'h3FF, 0, 1);
    end
    idle();
    check("R3 gapped count", int'(wr_count), 2);
    read_word("R3 gapped k0", 20);
    read_word("R3 gapped k1", 22);
  endtask

  task automatic t_window();
    clear_buf();
    rate_code = 2'd3;
    for (int i = 0; i < 3; i++) push(SW'(i), 1, 0);
    idle();
    check("R4 closed window", int'(wr_count), 0);
    push(10'h111, 1, 1); push(10'h112, 1, 1);
    push(10'h000, 1, 0);
    push(10'h122, 1, 1); push(10'h123, 1, 1);
    idle();
    check("R5 restart count", int'(wr_count), 2);
    read_word("R5 first window", 16'h0111);
    read_word("R5 second window", 16'h0122);
  endtask

  task automatic t_full();
    clear_buf();
    rate_code = 2'd0;
    for (int i = 0; i < DP + 4; i++) push(SW'(100 + i), 1, 1);
    idle();
    check("R8 count", int'(wr_count), DP);
    check("R8 full", int'(buf_full), 1);
    for (int i = 0; i < DP; i++) read_word("R8 kept", 100 + i);
    read_byte("R7 after full", 0);
  endtask

  task automatic t_clear_midword();
    clear_buf();
    rate_code = 2'd0;
    push(10'h2AB, 1, 1); push(10'h155, 1, 1);
    idle();
    read_byte("R9 pre", 8'h02);
    clear_buf();
    check("R9 count", int'(wr_count), 0);
    check("R9 full", int'(buf_full), 0);
    read_byte("R9 empty after clear", 0);
    push(10'h3C4, 1, 1);
    idle();
    read_word("R9 phase reset", 16'h03C4);
  endtask

  initial begin
    rst_n = 1'b0; smp_vld = 1'b0; smp_data = '0; rate_code = '0;
    acq_win = 1'b0; ptr_clr = 1'b0; rd_req = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_every_sample();
    t_div3();
    t_gapped();
    t_window();
    t_full();
    t_clear_midword();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule